// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the raster timing for an LCD panel. A horizontal counter steps once per pixel-clock enable and covers a line whose length is a multiple of eight pixel clocks. A vertical counter steps once per line. From these counters the block derives the following outputs:

- a display-enable window, which can be shifted right and down by separate start offsets for TFT panels (keep both offsets at zero for STN panels);
- a line pulse with its own start, width and polarity;
- a status flag that shows whether the current line is outside the vertical display area;
- a sticky end-of-frame flag with a maskable interrupt.

Software sets the block up by writing whole 32-bit words to seven selectable registers. A two-bit power field in the status register turns the block on. At reset the block is in power save. In power save the counters are held at zero and every output sits at its inactive level.

The main state machine tracks the vertical phase and has four states:

- `VP_IDLE`: power save.
- `VP_LEAD`: lines above the display area.
- `VP_DISP`: display lines.
- `VP_TRAIL`: lines below the display area.

It has these transitions:

- `VP_IDLE` moves to the start phase when the power field reads run. The start phase is `VP_DISP` when the vertical offset is zero and `VP_LEAD` otherwise.
- `VP_LEAD` moves to `VP_DISP` when the next line number equals the vertical offset.
- `VP_DISP` moves to `VP_TRAIL` when the next line number equals the offset plus the display height.
- Any running state returns to the start phase on the frame wrap.
- Any running state drops to `VP_IDLE` when the power field leaves run.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the following hold: power save; `hcount_o` and `vcount_o` at 0; `de_o` low; `lpulse_o` high (active-low polarity, inactive); `vnd_o` high; `frame_flag_o` and `frame_irq_o` low.
- R2: The power field is bits 1:0 of the status register (select 1). Only 2'b11 runs. With any other value, both counters read 0 from the next clock edge on. From the edge after that, `de_o` is low, `vnd_o` is high and `lpulse_o` sits at its inactive level.
- R3: The select-2 register holds a line-length field at bits 22:16 (call it L) and a display-width field at bits 6:0. While running, `hcount_o` advances on each clock with `pix_ce` high and wraps from (L+1)*8-1 to 0.
- R4: The select-3 register holds a frame-length field at bits 25:16 (call it F) and a display-height field at bits 9:0. `vcount_o` advances when `hcount_o` wraps and goes from F back to 0.
- R5: `de_o` is high exactly when both of these hold: `hcount_o` lies in [HS, HS+(W+1)*8), and `vcount_o` lies in [VS, VS+H+1). HS is select 4 bits 9:0, W is the display-width field, VS is select 5 bits 9:0 and H is the display-height field.
- R6: `vnd_o` is low exactly on lines inside the vertical display range of R5 while running, and high otherwise.
- R7: The select-6 register holds a start position at bits 25:16 (call it S) and a width field at bits 6:0 (call it K). The line pulse is active when `hcount_o` lies in [S, S+K+1).
- R8: Bit 7 of select 6 sets the pulse polarity: 1 drives the active pulse high, 0 drives it low. When the pulse is inactive, `lpulse_o` is the opposite level.
- R9: `frame_flag_o` sets on the clock edge where `vcount_o` wraps from F to 0. Writing select 1 with bit 31 set clears it. A set in the same cycle wins over the clear.
- R10: `frame_irq_o` equals `frame_flag_o` gated by bit 0 of the select-0 register.
- R11: While `pix_ce` is low, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 to 6; 7 is ignored) |
| wr_data | input | 32 | Register write data |
| hcount_o | output | 10 | Horizontal position in pixel clocks |
| vcount_o | output | 10 | Line number |
| de_o | output | 1 | Display enable |
| lpulse_o | output | 1 | Line pulse, polarity applied |
| vnd_o | output | 1 | Vertical non-display status |
| frame_flag_o | output | 1 | Sticky end-of-frame flag |
| frame_irq_o | output | 1 | Frame interrupt request |

## Verification
A register write takes effect on the rising edge that samples it. The state machine reads the new power field one edge later, so counting starts from the second edge after the write. A counter step and a flag set both show on the edge that causes them. The outputs decode the registered counters and state without further delay, so every result is due right after the rising edge that changes its inputs. The bench advances an independent model of the counters, phase and flag on each rising edge, using the inputs as they stood before that edge. It then compares every output with the model at the next falling edge, which stays in step with both the one-edge and the two-edge delays.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    parameter int HT_W  = 7;          // line length field, units of 8 pixel clocks
    parameter int VT_W  = 10;         // frame length field, lines
    parameter int HS_W  = 10;         // horizontal offset field
    parameter int VS_W  = 10;         // vertical offset field
    parameter int LS_W  = 10;         // line pulse start field
    parameter int LW_W  = 7;          // line pulse width field
    parameter int REG_W = 32;         // register write width
    parameter int HC_W  = HT_W + 3;   // pixel counter width

    typedef enum logic [2:0] {
        SEL_IRQEN  = 3'd0,
        SEL_STAT   = 3'd1,
        SEL_HTIME  = 3'd2,
        SEL_VTIME  = 3'd3,
        SEL_HSTART = 3'd4,
        SEL_VSTART = 3'd5,
        SEL_LPULSE = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        VP_IDLE  = 2'd0,
        VP_LEAD  = 2'd1,
        VP_DISP  = 2'd2,
        VP_TRAIL = 2'd3
    } vphase_e;

    typedef struct packed {
        logic [HT_W-1:0] h_tot;
        logic [HT_W-1:0] h_disp;
        logic [VT_W-1:0] v_tot;
        logic [VT_W-1:0] v_disp;
        logic [HS_W-1:0] h_start;
        logic [VS_W-1:0] v_start;
        logic [LS_W-1:0] lp_start;
        logic [LW_W-1:0] lp_width;
        logic            lp_pol;
        logic            irq_en;
        logic [1:0]      pwr;
    } tcfg_t;

    localparam logic [1:0] PWR_RUN = 2'b11;

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             frame_evt,
    output tcfg_t            cfg,
    output logic             frame_flag
);

    localparam int HTOT_LSB = 16;
    localparam int VTOT_LSB = 16;
    localparam int LPS_LSB  = 16;
    localparam int POL_BIT  = 7;
    localparam int CLR_BIT  = 31;

    reg_sel_e sel;
    logic     clr_req;

    assign sel     = reg_sel_e'(wr_sel);
    assign clr_req = wr_en && (sel == SEL_STAT) && wr_data[CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_IRQEN:  cfg.irq_en <= wr_data[0];
                SEL_STAT:   cfg.pwr    <= wr_data[1:0];
                SEL_HTIME: begin
                    cfg.h_tot  <= wr_data[HTOT_LSB +: HT_W];
                    cfg.h_disp <= wr_data[HT_W-1:0];
                end
                SEL_VTIME: begin
                    cfg.v_tot  <= wr_data[VTOT_LSB +: VT_W];
                    cfg.v_disp <= wr_data[VT_W-1:0];
                end
                SEL_HSTART: cfg.h_start <= wr_data[HS_W-1:0];
                SEL_VSTART: cfg.v_start <= wr_data[VS_W-1:0];
                SEL_LPULSE: begin
                    cfg.lp_start <= wr_data[LPS_LSB +: LS_W];
                    cfg.lp_pol   <= wr_data[POL_BIT];
                    cfg.lp_width <= wr_data[LW_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // sticky end-of-frame flag: a set beats a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         frame_flag <= 1'b0;
        else if (frame_evt) frame_flag <= 1'b1;
        else if (clr_req)   frame_flag <= 1'b0;
    end

endmodule

// File: rtl/lcdt_hgen.sv
module lcdt_hgen
    import lcdt_pkg::*;
#(
    parameter int HTW = HT_W,
    parameter int HSW = HS_W,
    parameter int LSW = LS_W,
    parameter int LWW = LW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ce,
    input  logic [HTW-1:0]   h_tot,
    input  logic [HTW-1:0]   h_disp,
    input  logic [HSW-1:0]   h_start,
    input  logic [LSW-1:0]   lp_start,
    input  logic [LWW-1:0]   lp_width,
    output logic [HTW+2:0]   h_q,
    output logic             line_end,
    output logic             h_win,
    output logic             lp_act
);

    localparam int HCW  = HTW + 3;
    localparam int MAXW = (HCW > HSW) ? ((HCW > LSW) ? HCW : LSW)
                                      : ((HSW > LSW) ? HSW : LSW);
    localparam int CW   = MAXW + 2;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] h_ext, span_tot, span_disp, win_end, lp_end;
    logic          h_last;

    assign h_ext     = CW'(h_q);
    assign span_tot  = (CW'(h_tot)  + ONE) << 3;
    assign span_disp = (CW'(h_disp) + ONE) << 3;
    assign win_end   = CW'(h_start) + span_disp;
    assign lp_end    = CW'(lp_start) + CW'(lp_width) + ONE;

    assign h_last    = (h_ext == span_tot - ONE);
    assign line_end  = !clr && ce && h_last;
    assign h_win     = (h_ext >= CW'(h_start)) && (h_ext < win_end);
    assign lp_act    = (h_ext >= CW'(lp_start)) && (h_ext < lp_end);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   h_q <= '0;
        else if (clr) h_q <= '0;
        else if (ce)  h_q <= h_last ? '0 : h_q + 1'b1;
    end

endmodule

// File: rtl/lcdt_vseq.sv
module lcdt_vseq
    import lcdt_pkg::*;
#(
    parameter int VTW = VT_W,
    parameter int VSW = VS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_on,
    input  logic           line_end,
    input  logic [VTW-1:0] v_tot,
    input  logic [VTW-1:0] v_disp,
    input  logic [VSW-1:0] v_start,
    output logic [VTW-1:0] v_q,
    output vphase_e        phase,
    output logic           clr,
    output logic           frame_evt
);

    localparam int CW = ((VTW > VSW) ? VTW : VSW) + 2;
    localparam logic [CW-1:0] ONE = CW'(1);

    vphase_e       nxt, start_ph;
    logic [CW-1:0] nv, disp_end;

    assign nv        = CW'(v_q) + ONE;
    assign disp_end  = CW'(v_start) + CW'(v_disp) + ONE;
    assign clr       = (phase == VP_IDLE) || !pwr_on;
    assign frame_evt = line_end && (v_q == v_tot);
    assign start_ph  = (v_start == '0) ? VP_DISP : VP_LEAD;

    always_comb begin
        nxt = phase;
        unique case (phase)
            VP_IDLE: begin
                if (pwr_on) nxt = start_ph;
            end
            VP_LEAD: begin
                if (!pwr_on)                               nxt = VP_IDLE;
                else if (frame_evt)                        nxt = start_ph;
                else if (line_end && nv == CW'(v_start))   nxt = VP_DISP;
            end
            VP_DISP: begin
                if (!pwr_on)                               nxt = VP_IDLE;
                else if (frame_evt)                        nxt = start_ph;
                else if (line_end && nv == disp_end)       nxt = VP_TRAIL;
            end
            VP_TRAIL: begin
                if (!pwr_on)                               nxt = VP_IDLE;
                else if (frame_evt)                        nxt = start_ph;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= VP_IDLE;
        else        phase <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        v_q <= '0;
        else if (clr)      v_q <= '0;
        else if (line_end) v_q <= frame_evt ? '0 : v_q + 1'b1;
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ce,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [HC_W-1:0]  hcount_o,
    output logic [VT_W-1:0]  vcount_o,
    output logic             de_o,
    output logic             lpulse_o,
    output logic             vnd_o,
    output logic             frame_flag_o,
    output logic             frame_irq_o
);

    tcfg_t   cfg;
    vphase_e phase;
    logic    pwr_on, clr, line_end, frame_evt, h_win, lp_act, run, frame_flag;

    assign pwr_on = (cfg.pwr == PWR_RUN);

    lcdt_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .frame_evt  (frame_evt),
        .cfg        (cfg),
        .frame_flag (frame_flag)
    );

    lcdt_hgen #(
        .HTW (HT_W),
        .HSW (HS_W),
        .LSW (LS_W),
        .LWW (LW_W)
    ) hgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ce       (pix_ce),
        .h_tot    (cfg.h_tot),
        .h_disp   (cfg.h_disp),
        .h_start  (cfg.h_start),
        .lp_start (cfg.lp_start),
        .lp_width (cfg.lp_width),
        .h_q      (hcount_o),
        .line_end (line_end),
        .h_win    (h_win),
        .lp_act   (lp_act)
    );

    lcdt_vseq #(
        .VTW (VT_W),
        .VSW (VS_W)
    ) vseq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_on    (pwr_on),
        .line_end  (line_end),
        .v_tot     (cfg.v_tot),
        .v_disp    (cfg.v_disp),
        .v_start   (cfg.v_start),
        .v_q       (vcount_o),
        .phase     (phase),
        .clr       (clr),
        .frame_evt (frame_evt)
    );

    // output decode from registered counters and phase
    always_comb begin
        run          = (phase != VP_IDLE);
        de_o         = run && (phase == VP_DISP) && h_win;
        lpulse_o     = cfg.lp_pol ? (run && lp_act) : !(run && lp_act);
        vnd_o        = (phase != VP_DISP);
        frame_flag_o = frame_flag;
        frame_irq_o  = frame_flag && cfg.irq_en;
    end

endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk
    import lcdt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_on,
    input logic            run,
    input logic            pix_ce,
    input logic [HC_W-1:0] hcount,
    input logic [VT_W-1:0] vcount,
    input logic            de,
    input logic            vnd,
    input logic            lp,
    input logic            lp_pol,
    input logic            flag
);

    assert_save_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (hcount == '0 && vcount == '0));

    assert_idle_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (lp == !lp_pol && !de && vnd));

    assert_de_in_vdisp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> !vnd);

    assert_flag_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> vcount == '0);

    assert_ce_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pwr_on && !pix_ce) |=> ($stable(hcount) && $stable(vcount)));

endmodule

bind lcd_timing_gen lcdt_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_on (pwr_on),
    .run    (run),
    .pix_ce (pix_ce),
    .hcount (hcount_o),
    .vcount (vcount_o),
    .de     (de_o),
    .vnd    (vnd_o),
    .lp     (lpulse_o),
    .lp_pol (cfg.lp_pol),
    .flag   (frame_flag_o)
);

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [9:0]  hcount_o;
    logic [9:0]  vcount_o;
    logic        de_o, lpulse_o, vnd_o, frame_flag_o, frame_irq_o;

    int n_run  = 0;
    int n_fail = 0;

    // reference model state
    int m_run = 0, m_h = 0, m_v = 0, m_flag = 0;
    int m_ht = 0, m_hd = 0, m_vt = 0, m_vd = 0, m_hs = 0, m_vs = 0;
    int m_ls = 0, m_lw = 0, m_pol = 0, m_ie = 0, m_pwr = 0;

    always #4 clk = ~clk;   // 125 MHz

    lcd_timing_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_ce       (pix_ce),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .hcount_o     (hcount_o),
        .vcount_o     (vcount_o),
        .de_o         (de_o),
        .lpulse_o     (lpulse_o),
        .vnd_o        (vnd_o),
        .frame_flag_o (frame_flag_o),
        .frame_irq_o  (frame_irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // one rising edge of the reference model, using pre-edge values
    task automatic model_step(input bit wr, input int sel, input logic [31:0] d, input bit ce);
        int htot;
        bit clr, le, fe;
        htot = (m_ht + 1) * 8;
        clr  = (m_run == 0) || (m_pwr != 3);
        le   = !clr && ce && (m_h == htot - 1);
        fe   = le && (m_v == m_vt);
        if (clr) begin
            m_h = 0; m_v = 0;
        end else if (ce) begin
            m_h = (m_h == htot - 1) ? 0 : m_h + 1;
            if (le) m_v = fe ? 0 : m_v + 1;
        end
        m_run = (m_pwr == 3) ? 1 : 0;
        if (fe) m_flag = 1;
        else if (wr && sel == 1 && d[31]) m_flag = 0;
        if (wr) begin
            case (sel)
                0: m_ie  = int'(d[0]);
                1: m_pwr = int'(d[1:0]);
                2: begin m_ht = int'(d[22:16]); m_hd = int'(d[6:0]); end
                3: begin m_vt = int'(d[25:16]); m_vd = int'(d[9:0]); end
                4: m_hs = int'(d[9:0]);
                5: m_vs = int'(d[9:0]);
                6: begin m_ls = int'(d[25:16]); m_pol = int'(d[7]); m_lw = int'(d[6:0]); end
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        bit disp, act;
        int e_lp;
        disp = (m_run != 0) && (m_v >= m_vs) && (m_v < m_vs + m_vd + 1);
        act  = (m_run != 0) && (m_h >= m_ls) && (m_h < m_ls + m_lw + 1);
        e_lp = m_pol ? int'(act) : int'(!act);
        chk("R3 hcount", int'(hcount_o), m_h);
        chk("R4 vcount", int'(vcount_o), m_v);
        chk("R5 de", int'(de_o),
            int'(disp && (m_h >= m_hs) && (m_h < m_hs + (m_hd + 1) * 8)));
        chk("R6 vnd", int'(vnd_o), int'(!disp));
        chk("R7 R8 lpulse", int'(lpulse_o), e_lp);
        chk("R9 flag", int'(frame_flag_o), m_flag);
        chk("R10 irq", int'(frame_irq_o), int'(m_flag != 0 && m_ie != 0));
    endtask

    // called at a falling edge; one clock with full comparison
    task automatic cyc(input bit wr, input int sel, input logic [31:0] d, input bit ce);
        wr_en = wr; wr_sel = 3'(sel); wr_data = d; pix_ce = ce;
        @(posedge clk);
        model_step(wr, sel, d, ce);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        cyc(1'b1, sel, d, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 32'd0, 1'b1);
    endtask

    task automatic t_reset();
        compare_all();
        chk("R1 lpulse idle high", int'(lpulse_o), 1);
        chk("R1 vnd high", int'(vnd_o), 1);
        chk("R1 hcount zero", int'(hcount_o), 0);
        idle(5);
        chk("R1 still saved hcount", int'(hcount_o), 0);
    endtask

    task automatic t_basic();
        wr(2, (32'd1 << 16) | 32'd0);             // 16 clocks/line, 8 displayed
        wr(3, (32'd4 << 16) | 32'd1);             // 5 lines, 2 displayed
        wr(4, 32'd0);
        wr(5, 32'd0);
        wr(6, (32'd3 << 16) | (32'd1 << 7) | 32'd1);
        wr(0, 32'd1);
        wr(1, 32'd3);
        chk("R2 first edge after start", int'(hcount_o), 0);
        idle(240);
        chk("R9 flag set after frames", int'(frame_flag_o), 1);
        chk("R10 irq raised", int'(frame_irq_o), 1);
    endtask

    task automatic t_offsets();
        wr(1, 32'h8000_0000);                     // save, clear flag
        wr(2, (32'd2 << 16) | 32'd1);             // 24 clocks/line, 16 displayed
        wr(3, (32'd6 << 16) | 32'd2);             // 7 lines, 3 displayed
        wr(4, 32'd5);
        wr(5, 32'd2);
        wr(6, (32'd20 << 16) | 32'd6);            // active low, 7 wide
        wr(1, 32'd3);
        idle(24 * 7 * 2 + 10);
    endtask

    task automatic t_ce();
        bit ce;
        for (int i = 0; i < 300; i++) begin
            ce = (i % 3) != 0;
            cyc(1'b0, 0, 32'd0, ce);
        end
        chk("R11 counters moved", int'(hcount_o != 0 || vcount_o != 0), 1);
    endtask

    task automatic t_clear();
        wr(0, 32'd0);
        chk("R10 irq masked", int'(frame_irq_o), 0);
        wr(1, 32'h8000_0003);
        idle(100);
        wr(1, 32'h8000_0003);
        wr(0, 32'd1);
        for (int i = 0; i < 200; i++) begin
            cyc(1'b1, 1, 32'h8000_0003, 1'b1);   // clear every cycle; wrap must win
        end
        idle(20);
    endtask

    task automatic t_save();
        wr(1, 32'd0);
        idle(40);
        chk("R2 save hcount", int'(hcount_o), 0);
        chk("R2 save vcount", int'(vcount_o), 0);
        chk("R2 save de", int'(de_o), 0);
        wr(1, 32'd1);
        idle(20);
        chk("R2 reserved code holds", int'(hcount_o), 0);
        wr(1, 32'd2);
        idle(20);
        wr(1, 32'd3);
        idle(100);
    endtask

    task automatic t_edge();
        wr(1, 32'd0);
        wr(2, (32'd0 << 16) | 32'd0);             // 8 clocks/line
        wr(3, (32'd3 << 16) | 32'd0);
        wr(5, 32'd9);                             // offset past frame end
        wr(6, (32'd900 << 16) | (32'd1 << 7) | 32'd5);
        wr(7, 32'hFFFF_FFFF);                     // unused select
        wr(1, 32'd3);
        idle(120);
        chk("R5 never displays", int'(de_o), 0);
        chk("R7 never pulses", int'(lpulse_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_offsets();
        t_ce();
        t_clear();
        t_save();
        t_edge();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule